// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a microcontroller peripheral bus. It sits idle after system reset and begins counting peripheral clock cycles only when software writes a start key, 0xAC, to its enable register. If software does not write the key again before the selected interval runs out, the block overflows. Depending on how it is configured, an overflow raises either a one-cycle internal reset pulse or a one-cycle non-maskable interrupt request pulse.

A small mode register sets two things: the overflow interval, which is one of eight powers of two of the clock period, and the overflow action. Software is expected to write this register exactly once after reset, even if it keeps the defaults, because the register locks after its first write. The time base counts from the moment of the start or kick write, so every interval is exact to the cycle. The lowest interval exponent is the parameter `BASE_LOG`, with a default of 19, so the defaults span 2^19 to 2^26 clocks.

The sequencer has four named states:
- `ST_IDLE`: stopped.
- `ST_RUN`: counting.
- `ST_NMI`: one cycle that raises the interrupt pulse while counting continues.
- `ST_TRIP`: one cycle that raises the reset pulse.

Its transitions are:
- START: `ST_IDLE` to `ST_RUN` on a key write.
- KICK: `ST_RUN` or `ST_NMI` to `ST_RUN` on a key write, which clears the count.
- WRAP: `ST_RUN` or `ST_NMI` to `ST_NMI` on an overflow in interrupt mode.
- FIRE: `ST_RUN` or `ST_NMI` to `ST_TRIP` on an overflow in reset mode.
- SETTLE: `ST_NMI` to `ST_RUN` with no key and no overflow.
- HALT: `ST_TRIP` to `ST_IDLE`, taken unconditionally.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is stopped. Both pulse outputs stay 0 until a key write, and a read of address 0 returns 0x07.
- R2: A write of 0xAC to address 1 while stopped starts the count. The first overflow pulse is visible in the cycle that follows the N-th rising edge after the write edge, where N = 2^(BASE_LOG+sel).
- R3: The select field in mode bits [2:0] picks sel, covering 0 to 7, and its reset value is 7.
- R4: When the action field in mode bits [5:4] is anything other than 01 (reset action), an overflow drives `wdt_rst_o` high for exactly one cycle. The timer then stays stopped until another key write.
- R5: When the action field is 01 (interrupt action), an overflow drives `wdt_nmi_o` high for exactly one cycle. Counting continues and the pulse repeats every N cycles.
- R6: A 0xAC write to address 1 while counting clears the count. The next overflow comes N cycles after that write.
- R7: A write to address 1 of any value other than 0xAC neither starts nor restarts the timer.
- R8: The mode register takes only its first write after reset, keeping bits [5:4] and [2:0]. Later writes are ignored until reset. A read of address 0 returns the stored value with all other bits 0.
- R9: A read of address 1 always returns 0x9A.
- R10: When a key write lands on the same edge as an overflow, the key write wins: no pulse occurs and a new interval of N cycles begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 is mode, 1 is enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| wdt_rst_o | output | 1 | One-cycle internal reset pulse on overflow |
| wdt_nmi_o | output | 1 | One-cycle non-maskable interrupt request pulse on overflow |

## Verification
The kick and the overflow can fall on the same clock edge. The bench provokes this by starting the timer with the shortest interval and then issuing a second key write whose edge is exactly the N-th edge after the start. Neither pulse may appear in the following cycle, and the next pulse must arrive a full N cycles after the kick. This is checked in both reset and interrupt action.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_NMI  = 2'd2,
        ST_TRIP = 2'd3
    } wd_state_t;

    localparam int          SEL_W        = 3;
    localparam int          ACT_W        = 2;
    localparam int          SEL_LSB      = 0;
    localparam int          ACT_LSB      = 4;
    localparam logic [7:0]  START_KEY    = 8'hAC;
    localparam logic [7:0]  ENA_READBACK = 8'h9A;
    localparam logic [ACT_W-1:0] ACT_NMI = 2'b01;
    localparam logic [SEL_W-1:0] SEL_RST = 3'd7;
endpackage

// File: rtl/kwd_modereg.sv
module kwd_modereg
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       mode_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             nmi_sel_o
);
    logic             locked_q;
    logic [SEL_W-1:0] sel_q;
    logic [ACT_W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            sel_q    <= SEL_RST;
            act_q    <= '0;
        end else if (wr_i && !locked_q) begin
            locked_q <= 1'b1;
            sel_q    <= wdata_i[SEL_LSB +: SEL_W];
            act_q    <= wdata_i[ACT_LSB +: ACT_W];
        end
    end

    always_comb begin
        mode_o                    = '0;
        mode_o[SEL_LSB +: SEL_W]  = sel_q;
        mode_o[ACT_LSB +: ACT_W]  = act_q;
    end

    assign sel_o     = sel_q;
    assign nmi_sel_o = (act_q == ACT_NMI);

    // R8: once locked, the stored mode never changes
    a_r8_write_once: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(mode_o));
endmodule

// File: rtl/kwd_timebase.sv
module kwd_timebase
    import kwd_pkg::*;
#(
    parameter int BASE_LOG = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             due_o
);
    localparam int NSEL = 1 << SEL_W;
    localparam int CW   = BASE_LOG + NSEL - 1;

    logic [CW-1:0]   cnt_q;
    logic [NSEL-1:0] tap;

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_tap
            assign tap[g] = &cnt_q[BASE_LOG+g-1:0];
        end
    endgenerate

    assign due_o = run_i & tap[sel_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (run_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // R6: a clear request always leaves the count at zero
    a_r6_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm
    import kwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic due_i,
    input  logic nmi_sel_i,
    output logic run_o,
    output logic clr_o,
    output logic wdt_rst_o,
    output logic wdt_nmi_o
);
    wd_state_t state_q, state_d;
    logic      counting;

    assign counting = (state_q == ST_RUN) || (state_q == ST_NMI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (kick_i) state_d = ST_RUN;               // START
            ST_RUN, ST_NMI: begin
                if (kick_i)      state_d = ST_RUN;               // KICK
                else if (due_i)  state_d = nmi_sel_i ? ST_NMI    // WRAP
                                                     : ST_TRIP;  // FIRE
                else             state_d = ST_RUN;               // SETTLE
            end
            ST_TRIP: state_d = ST_IDLE;                          // HALT
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run_o     = counting;
        clr_o     = kick_i | !counting | due_i;
        wdt_rst_o = (state_q == ST_TRIP);
        wdt_nmi_o = (state_q == ST_NMI);
    end

    // R1: without a key the stopped state is kept
    a_r1_stay_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !kick_i) |=> (state_q == ST_IDLE));
    // R4: reset pulse is one cycle and leaves the timer stopped
    a_r4_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> (!wdt_rst_o && state_q == ST_IDLE));
    // R5: interrupt pulse is one cycle and counting goes on
    a_r5_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_nmi_o |=> (!wdt_nmi_o && run_o));
    // R10: a kick on an overflow edge suppresses both pulses
    a_r10_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && kick_i) |=> (!wdt_rst_o && !wdt_nmi_o));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int BASE_LOG = 19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wdt_rst_o,
    output logic       wdt_nmi_o
);
    logic             wr_mode, kick;
    logic [7:0]       mode_val;
    logic [SEL_W-1:0] sel;
    logic             nmi_sel, run, clr, due;

    assign wr_mode   = bus_wr && !bus_addr;
    assign kick      = bus_wr && bus_addr && (bus_wdata == START_KEY);
    assign bus_rdata = bus_addr ? ENA_READBACK : mode_val;

    kwd_modereg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_mode),
        .wdata_i   (bus_wdata),
        .mode_o    (mode_val),
        .sel_o     (sel),
        .nmi_sel_o (nmi_sel)
    );

    kwd_timebase #(.BASE_LOG(BASE_LOG)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .clr_i (clr),
        .sel_i (sel),
        .due_o (due)
    );

    kwd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick_i    (kick),
        .due_i     (due),
        .nmi_sel_i (nmi_sel),
        .run_o     (run),
        .clr_o     (clr),
        .wdt_rst_o (wdt_rst_o),
        .wdt_nmi_o (wdt_nmi_o)
    );

    // R4/R5: the two overflow outputs are never high together
    a_r5_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdt_rst_o && wdt_nmi_o));
endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
    localparam int BL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wdt_rst_o, wdt_nmi_o;
    int         total = 0, bad = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog #(.BASE_LOG(BL)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_o(wdt_rst_o), .wdt_nmi_o(wdt_nmi_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // kind: 0 none, 1 reset pulse, 2 interrupt pulse, 3 both
    task automatic wait_pulse(input int limit, output int cyc, output int kind);
        cyc = 0; kind = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (wdt_rst_o || wdt_nmi_o) begin
                cyc  = i;
                kind = (wdt_rst_o ? 1 : 0) + (wdt_nmi_o ? 2 : 0);
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        int c, k, n;
        do_reset();

        // R1 / R9: reset state
        check(!wdt_rst_o && !wdt_nmi_o, "R1 outputs idle", int'(wdt_rst_o) + int'(wdt_nmi_o), 0);
        bus_read(1'b0, rv); check(rv == 8'h07, "R1 mode reset value", rv, 8'h07);
        bus_read(1'b1, rv); check(rv == 8'h9A, "R9 enable readback", rv, 8'h9A);
        wait_pulse(600, c, k); check(k == 0, "R1 stopped without key", k, 0);

        // R3 / R4: default interval 2^(BL+7), reset action
        bus_write(1'b1, 8'hAC);
        wait_pulse(600, c, k);
        check(c == 512, "R3 default interval", c, 512);
        check(k == 1, "R4 default action reset", k, 1);
        @(negedge clk); check(!wdt_rst_o, "R4 single-cycle pulse", int'(wdt_rst_o), 0);
        wait_pulse(1100, c, k); check(k == 0, "R4 stopped after reset pulse", k, 0);

        // R2 / R3 / R4 / R5: sweep over every select value and action codes 00, 01, 11
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 3; a++) begin
                logic [1:0] act;
                act = (a == 0) ? 2'b00 : (a == 1) ? 2'b01 : 2'b11;
                n = 4 << s;
                do_reset();
                bus_write(1'b0, {2'b00, act, 1'b0, 3'(s)});
                bus_write(1'b1, 8'hAC);
                wait_pulse(n + 8, c, k);
                check(c == n, "R2 R3 interval", c, n);
                check(k == ((act == 2'b01) ? 2 : 1), "R4 R5 action", k, (act == 2'b01) ? 2 : 1);
                @(negedge clk);
                check(!wdt_rst_o && !wdt_nmi_o, "R4 R5 pulse width", int'(wdt_rst_o) + int'(wdt_nmi_o), 0);
                if (act == 2'b01) begin
                    wait_pulse(n + 8, c, k);
                    check(c == n - 1 && k == 2, "R5 repeat interval", c, n - 1);
                end else begin
                    wait_pulse(2 * n + 8, c, k);
                    check(k == 0, "R4 no repeat", k, 0);
                end
            end
        end

        // R6: kick while running restarts the interval
        do_reset();
        bus_write(1'b0, 8'h11);
        bus_write(1'b1, 8'hAC);
        wait_pulse(5, c, k); check(k == 0, "R6 no early pulse", k, 0);
        bus_write(1'b1, 8'hAC);
        wait_pulse(20, c, k); check(c == 8 && k == 2, "R6 restart after kick", c, 8);

        // R10: kick on the overflow edge, interrupt action then reset action
        for (int a = 0; a < 2; a++) begin
            do_reset();
            bus_write(1'b0, (a == 0) ? 8'h10 : 8'h00);
            bus_write(1'b1, 8'hAC);
            wait_pulse(3, c, k); check(k == 0, "R10 no pulse before collision", k, 0);
            bus_write(1'b1, 8'hAC);
            check(!wdt_rst_o && !wdt_nmi_o, "R10 collision suppresses pulse",
                  int'(wdt_rst_o) + int'(wdt_nmi_o), 0);
            wait_pulse(12, c, k);
            check(c == 4, "R10 new interval after collision", c, 4);
            check(k == ((a == 0) ? 2 : 1), "R10 action after collision", k, (a == 0) ? 2 : 1);
        end

        // R7: non-key values on the enable register
        do_reset();
        bus_write(1'b0, 8'h10);
        bus_write(1'b1, 8'h55);
        wait_pulse(20, c, k); check(k == 0, "R7 non-key does not start", k, 0);
        bus_write(1'b1, 8'hAC);
        bus_write(1'b1, 8'hAB);
        wait_pulse(12, c, k); check(c == 3 && k == 2, "R7 non-key does not restart", c, 3);

        // R8: write-once mode register and read mask
        do_reset();
        bus_write(1'b0, 8'hFF);
        bus_read(1'b0, rv); check(rv == 8'h37, "R8 stored fields", rv, 8'h37);
        bus_write(1'b0, 8'h10);
        bus_read(1'b0, rv); check(rv == 8'h37, "R8 second write ignored", rv, 8'h37);
        bus_write(1'b1, 8'hAC);
        wait_pulse(600, c, k); check(c == 512 && k == 1, "R8 locked mode in effect", c, 512);
        do_reset();
        bus_read(1'b0, rv); check(rv == 8'h07, "R8 reset unlocks", rv, 8'h07);
        bus_write(1'b0, 8'h10);
        bus_read(1'b0, rv); check(rv == 8'h10, "R8 write after reset", rv, 8'h10);
        bus_read(1'b1, rv); check(rv == 8'h9A, "R9 enable readback later", rv, 8'h9A);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule